// File: doc/BRIEF.md
# Chip-Select-Timed Fault Report Latch

This block gathers a small 2-bit diagnostic code from each of several driver channels and keeps a held copy of them. The held copy is what a serial host reads. It is refreshed from the live codes only when serial chip select returns high. Because of this, a read always returns the state captured at the end of the previous frame. A code that changes while the host is idle, or in the middle of a frame, does not show until the frame after the one that follows the change.

At each chip-select rising edge the block also refreshes an active-low, open-drain fault flag. The flag is pulled low when the captured codes hold any fault and released when every live code is clear. At the chip-select falling edge the held codes are copied into a shift register. They leave on the serial output, highest channel first and the high bit of each code first, with one bit per serial clock falling edge. The serial output enable is low whenever chip select is high.

Two global controls act around the report path. The main enable behaves like a power-on clear: the held codes, the flag, the shift register and the gate outputs all go to zero. The gate enable only holds the gate outputs low; reporting carries on. Chip select and serial clock come from outside the chip, so each passes through a synchronizer. All outputs are registered.

Top module: `fault_report_core`

## Requirements
- R1: While `rst` is high, or while `en_main` is low, the held codes clear to 00 on every channel, `fault_pull` is 0, `so_en` is 0 and `gate_out` is all zero; a frame read after such a clear returns all zero bits.
- R2: The held codes change only at a synchronized rising edge of `cs_n`, and they then take the live codes present at that edge. A change of `live_code` at any other time does not alter the bits of the next frame.
- R3: At a `cs_n` rising edge where at least one live code is nonzero, `fault_pull` becomes 1 (the open-drain line is pulled low).
- R4: At a `cs_n` rising edge where every live code is 00, `fault_pull` becomes 0 (the line is released).
- R5: At a `cs_n` falling edge the held codes are loaded into the shift register, and `so_q` presents bit NCH*2-1 first. Channel k occupies bits 2k+1 (sent first) and 2k. Each synchronized falling edge of `sclk` while `cs_n` is low moves the next lower bit onto `so_q`.
- R6: `so_en` is 0 while the synchronized `cs_n` is high and 1 while it is low (with `en_main` high). Edges on `sclk` while `cs_n` is high do not shift.
- R7: While `en_gate` is low, `gate_out` is all zero. The held codes, the flag and the serial output keep working as in R2 to R5.
- R8: With `en_main` and `en_gate` both high, `gate_out` equals `gate_req` one clock later.
- R9: A frame always returns the codes captured at the end of the previous frame. Live codes that change during a frame appear only in the frame after it.
- R10: Fault code values: 00 none, 01 short to ground, 10 open load, 11 shorted load. Any value other than 00 counts as a fault for R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| en_main | input | 1 | Main enable; low clears all state |
| en_gate | input | 1 | Gate enable; low forces gates off only |
| cs_n | input | 1 | Serial chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| live_code | input | NCH*2 | Live 2-bit fault code per channel, channel k at bits 2k+1:2k |
| gate_req | input | NCH | Per-channel gate-on command |
| gate_out | output | NCH | Registered gate drive |
| so_q | output | 1 | Serial data out |
| so_en | output | 1 | Serial output enable (0 means high impedance) |
| fault_pull | output | 1 | 1 pulls the active-low fault line low |

## Verification
A `cs_n` or `sclk` edge acts SYNC_STAGES+1 clock edges after the first edge that samples it. At that edge the held codes, the flag, the shift load or shift, and `so_en` all update. `gate_out` follows `gate_req` and the enables after one edge. The bench model pushes each sampled `cs_n` and `sclk` value into a history line SYNC_STAGES+2 deep. It decides edges from the same positions of that line, and it compares every output at the falling clock edge that follows each update. The frame-level checks wait at least SYNC_STAGES+2 cycles after each pin change before reading `so_q`.

// File: rtl/fr_pkg.sv
package fr_pkg;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    FC_NONE  = 2'b00,
    FC_GND   = 2'b01,
    FC_OPEN  = 2'b10,
    FC_SHORT = 2'b11
  } fault_code_e;
endpackage

// File: rtl/fr_sync.sv
module fr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic level,
  output logic prev
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= {STAGES{RST_VAL}};
      prev <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      prev <= pipe[STAGES-1];
    end
  end

  assign level = pipe[STAGES-1];
endmodule

// File: rtl/fr_fault_latch.sv
module fr_fault_latch
  import fr_pkg::*;
#(
  parameter int NCH = 6,
  localparam int W = NCH * CODE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         capture,
  input  logic [W-1:0] live,
  output logic [W-1:0] latched,
  output logic         flag_pull
);
  logic [NCH-1:0] chan_bad;

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      logic [CODE_W-1:0] hold_q;
      assign chan_bad[ch] = (live[ch*CODE_W +: CODE_W] != FC_NONE);
      always_ff @(posedge clk) begin
        if (rst || clr) hold_q <= FC_NONE;
        else if (capture) hold_q <= live[ch*CODE_W +: CODE_W];
      end
      assign latched[ch*CODE_W +: CODE_W] = hold_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr) flag_pull <= 1'b0;
    else if (capture) flag_pull <= |chan_bad;
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (rst)
    clr |=> (latched == '0 && !flag_pull));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!capture && !clr) |=> $stable(latched));
  p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
    (capture && !clr && live != '0) |=> flag_pull);
  p_flag_rel_r4: assert property (@(posedge clk) disable iff (rst)
    (capture && !clr && live == '0) |=> !flag_pull);
endmodule

// File: rtl/fr_shifter.sv
module fr_shifter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic         shift,
  input  logic         active,
  input  logic [W-1:0] din,
  output logic         so_q,
  output logic         so_en
);
  logic [W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      shreg <= '0;
      so_en <= 1'b0;
    end else begin
      so_en <= active;
      if (load) shreg <= din;
      else if (shift && active) shreg <= {shreg[W-2:0], 1'b0};
    end
  end

  assign so_q = shreg[W-1];

  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !active |=> !so_en);
  p_load_r5: assert property (@(posedge clk) disable iff (rst)
    (load && !clr) |=> (so_q == $past(din[W-1])));
endmodule

// File: rtl/fr_gate_ctl.sv
module fr_gate_ctl #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_main,
  input  logic           en_gate,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gate
);
  always_ff @(posedge clk) begin
    if (rst || !en_main || !en_gate) gate <= '0;
    else gate <= req;
  end

  p_off_r7: assert property (@(posedge clk) disable iff (rst)
    !en_gate |=> gate == '0);
  p_follow_r8: assert property (@(posedge clk) disable iff (rst)
    (en_main && en_gate) |=> gate == $past(req));
endmodule

// File: rtl/fault_report_core.sv
module fault_report_core
  import fr_pkg::*;
#(
  parameter int NCH         = 6,
  parameter int SYNC_STAGES = 2,
  localparam int W = NCH * CODE_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_main,
  input  logic           en_gate,
  input  logic           cs_n,
  input  logic           sclk,
  input  logic [W-1:0]   live_code,
  input  logic [NCH-1:0] gate_req,
  output logic [NCH-1:0] gate_out,
  output logic           so_q,
  output logic           so_en,
  output logic           fault_pull
);
  logic cs_lvl, cs_prev, ck_lvl, ck_prev;
  logic cs_rise, cs_fall, ck_fall, clr;
  logic [W-1:0] held;

  fr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .d(cs_n), .level(cs_lvl), .prev(cs_prev));
  fr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ck_sync (
    .clk(clk), .rst(rst), .d(sclk), .level(ck_lvl), .prev(ck_prev));

  assign clr     = !en_main;
  assign cs_rise = cs_lvl & ~cs_prev;
  assign cs_fall = ~cs_lvl & cs_prev;
  assign ck_fall = ~ck_lvl & ck_prev;

  fr_fault_latch #(.NCH(NCH)) u_latch (
    .clk(clk), .rst(rst), .clr(clr), .capture(cs_rise),
    .live(live_code), .latched(held), .flag_pull(fault_pull));

  fr_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .clr(clr), .load(cs_fall), .shift(ck_fall),
    .active(~cs_lvl), .din(held), .so_q(so_q), .so_en(so_en));

  fr_gate_ctl #(.NCH(NCH)) u_gate (
    .clk(clk), .rst(rst), .en_main(en_main), .en_gate(en_gate),
    .req(gate_req), .gate(gate_out));
endmodule

// File: tb/fault_report_core_bench.sv
module fault_report_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 6;
  localparam int SYNC = 2;
  localparam int W    = NCH * 2;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst, en_main, en_gate, cs_n, sclk;
  logic [W-1:0] live_code;
  logic [NCH-1:0] gate_req, gate_out;
  logic so_q, so_en, fault_pull;
  logic flt_line;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_report_core #(.NCH(NCH), .SYNC_STAGES(SYNC)) u_fault_report_core (
    .clk(clk), .rst(rst), .en_main(en_main), .en_gate(en_gate),
    .cs_n(cs_n), .sclk(sclk), .live_code(live_code), .gate_req(gate_req),
    .gate_out(gate_out), .so_q(so_q), .so_en(so_en), .fault_pull(fault_pull));

  // open-drain fault line with a pull-up: driven low, otherwise released high
  assign flt_line = fault_pull ? 1'b0 : 1'b1;

  // behavioural reference model
  int h_cs [0:SYNC+1];
  int h_ck [0:SYNC+1];
  logic [W-1:0] m_held, m_sh;
  logic m_flag, m_so_en;
  logic [NCH-1:0] m_gate;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= SYNC+1; i++) begin h_cs[i] = 1; h_ck[i] = 0; end
      m_held = '0; m_sh = '0; m_flag = 0; m_so_en = 0; m_gate = '0;
    end else begin
      for (int i = SYNC+1; i > 0; i--) begin h_cs[i] = h_cs[i-1]; h_ck[i] = h_ck[i-1]; end
      h_cs[0] = cs_n; h_ck[0] = sclk;
      if (!en_main) begin
        m_held = '0; m_sh = '0; m_flag = 0; m_so_en = 0; m_gate = '0;
      end else begin
        if (h_cs[SYNC] == 0 && h_cs[SYNC+1] == 1) m_sh = m_held;
        else if (h_cs[SYNC] == 0 && h_ck[SYNC] == 0 && h_ck[SYNC+1] == 1)
          m_sh = m_sh << 1;
        if (h_cs[SYNC] == 1 && h_cs[SYNC+1] == 0) begin
          m_held = live_code;
          m_flag = (live_code != '0);
        end
        m_so_en = (h_cs[SYNC] == 0);
        m_gate = en_gate ? gate_req : '0;
      end
    end
  end

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, got, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && cyc > 2) begin
      check(en_gate ? "R8 gate_out" : "R7 gate_out", W'(gate_out), W'(m_gate));
      check("R6 so_en", W'(so_en), W'(m_so_en));
      if (so_en) check("R5 so_q", W'(so_q), W'(m_sh[W-1]));
      check("R3 or R4 fault line", W'(flt_line), W'(!m_flag));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_frame(output logic [W-1:0] got, input logic chg, input logic [W-1:0] nl);
    cs_n = 1'b0;
    wait_cyc(SYNC + 3);
    for (int i = 0; i < W; i++) begin
      got[W-1-i] = so_q;
      if (chg && i == 3) live_code = nl;
      sclk = 1'b1; wait_cyc(4);
      sclk = 1'b0; wait_cyc(4);
    end
    cs_n = 1'b1;
    wait_cyc(SYNC + 4);
  endtask

  logic [W-1:0] rd;
  localparam logic [W-1:0] PAT_A = 12'hC01; // ch5=11 shorted, ch0=01 gnd (R10)
  localparam logic [W-1:0] PAT_B = 12'h08C; // ch3=10 open, ch1=11
  localparam logic [W-1:0] PAT_C = 12'h400; // ch5=01 only

  initial begin
    rst = 1; en_main = 1; en_gate = 1; cs_n = 1; sclk = 0;
    live_code = '0; gate_req = '0;
    wait_cyc(5);
    rst = 0;
    wait_cyc(3);
    // R1: reset state at the ports
    check("R1 gate_out after reset", W'(gate_out), '0);
    check("R1 so_en after reset", W'(so_en), '0);
    check("R1 fault line released", W'(flt_line), W'(1));

    // R8: gates follow requests
    gate_req = 6'b101101; wait_cyc(2);
    check("R8 gate follow", W'(gate_out), W'(6'b101101));

    // R2 R9: live change while idle is not reported in next frame
    live_code = PAT_A; wait_cyc(10);
    run_frame(rd, 1'b0, '0);
    check("R9 first frame returns prior capture", rd, '0);
    check("R3 flag pulled after capture of faults", W'(flt_line), W'(0));
    run_frame(rd, 1'b0, '0);
    check("R5 frame order of pattern A", rd, PAT_A);

    // R2: mid-frame change shows one frame later
    run_frame(rd, 1'b1, PAT_B);
    check("R2 mid-frame change not visible", rd, PAT_A);
    run_frame(rd, 1'b0, '0);
    check("R2 change visible next frame", rd, PAT_B);

    // R4: clear live codes
    live_code = '0; wait_cyc(3);
    check("R4 flag holds until capture", W'(flt_line), W'(0));
    run_frame(rd, 1'b0, '0);
    check("R9 stale B returned", rd, PAT_B);
    check("R4 flag released", W'(flt_line), W'(1));
    run_frame(rd, 1'b0, '0);
    check("R4 clear report", rd, '0);

    // R6: sclk toggles with cs high do not shift
    live_code = PAT_C;
    run_frame(rd, 1'b0, '0);
    for (int k = 0; k < 5; k++) begin sclk = 1; wait_cyc(4); sclk = 0; wait_cyc(4); end
    check("R6 so_en low while idle", W'(so_en), '0);
    run_frame(rd, 1'b0, '0);
    check("R6 idle clocks left data whole", rd, PAT_C);

    // R7: gate enable low, reporting continues
    en_gate = 0; gate_req = '1; live_code = PAT_B; wait_cyc(2);
    check("R7 gates forced low", W'(gate_out), '0);
    run_frame(rd, 1'b0, '0);
    check("R7 report still works", rd, PAT_C);
    run_frame(rd, 1'b0, '0);
    check("R7 capture still works", rd, PAT_B);
    check("R7 flag still pulled", W'(flt_line), W'(0));
    en_gate = 1; wait_cyc(2);
    check("R8 gates resume", W'(gate_out), W'(6'b111111));

    // R1: main enable low clears everything
    en_main = 0; wait_cyc(3);
    check("R1 gates cleared", W'(gate_out), '0);
    check("R1 flag released", W'(flt_line), W'(1));
    live_code = '0;
    en_main = 1; wait_cyc(3);
    run_frame(rd, 1'b0, '0);
    check("R1 cleared report", rd, '0);

    wait_cyc(5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule